// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block turns a processor's 3-bit bus status code into the timed control strobes that memory and I/O devices need. It spends most of its time idle, with the status lines showing the passive code. A bus cycle begins when the status leaves the passive code. The block then does four things:

- It gives a one-clock address latch pulse.
- It sets the data direction line.
- It opens a command window with data enable and one command strobe: memory read, memory write, I/O read, I/O write or interrupt acknowledge.
- It holds that window until the status goes back to passive.

The code is captured once, at the start of the cycle. The command therefore cannot change while the cycle is running, even if the status lines change. A halt code runs a cycle that has the latch pulse but no command. All outputs are active high and are driven only from registers.

Top module: `busCmdController`

## Requirements
- R1: A cycle starts when the status is sampled at a rising edge with a value other than 111 and the previous sample was 111. In the clock that follows that edge, `addrLatchEn` is high for exactly one clock.
- R2: The command strobe is chosen by the code captured at cycle start: 000 gives `intAck`, 001 gives `ioRead`, 010 gives `ioWrite`, 100 and 101 give `memRead`, and 110 gives `memWrite`.
- R3: Code 011 (halt) produces the latch pulse. It raises no command strobe and no `dataEnable` at any point in the cycle.
- R4: The command strobe rises in the clock after the latch pulse. It stays high until the first rising edge at which the status is sampled as 111, and it is low after that edge. At most one command strobe is high at any time.
- R5: `dataEnable` is high exactly while a non-halt command strobe is high. It is never high in the same clock as `addrLatchEn`.
- R6: `dirTransmit` is high from the latch clock to the end of the cycle for codes 010 and 110. It is low for every other code and whenever no cycle is running.
- R7: The code captured at cycle start holds for the whole cycle. Status values other than 111 seen during the cycle do not change the strobes or the direction, and they do not start a new cycle.
- R8: If the status is sampled as 111 at the edge that ends the latch clock, the cycle is dropped. No command strobe and no `dataEnable` follow.
- R9: While `rstN` is low, and after it is released, every output is low. A cycle can only start after the status has been sampled as 111 at least once since reset.
- R10: A single passive sample between two cycles is enough. The next non-passive sample starts a new cycle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| busStatus | input | 3 | Processor bus status code; 111 means passive |
| addrLatchEn | output | 1 | One-clock address latch pulse at cycle start |
| dirTransmit | output | 1 | Data direction: high transmits (write cycles) |
| dataEnable | output | 1 | Data transceiver enable during the command window |
| memRead | output | 1 | Memory read command (fetch and memory read codes) |
| memWrite | output | 1 | Memory write command |
| ioRead | output | 1 | I/O read command |
| ioWrite | output | 1 | I/O write command |
| intAck | output | 1 | Interrupt acknowledge command |

## Verification
The hardest situations to reach are the ones where the status moves at an awkward moment. These include a return to passive right at the end of the latch clock, a different non-passive code during the command window, and a single passive sample between two cycles. Random stimulus seldom produces these in the right order. Directed sequences therefore place each of them on an exact edge. Random stimulus, about half of it passive, then runs against a cycle-level model in the bench, which compares every output on every clock.

// File: rtl/busCmdPkg.sv
package busCmdPkg;

  localparam int STATUS_W = 3;
  localparam int CMD_W    = 5;

  localparam logic [STATUS_W-1:0] CODE_INTA   = 3'b000;
  localparam logic [STATUS_W-1:0] CODE_IORD   = 3'b001;
  localparam logic [STATUS_W-1:0] CODE_IOWR   = 3'b010;
  localparam logic [STATUS_W-1:0] CODE_HALT   = 3'b011;
  localparam logic [STATUS_W-1:0] CODE_FETCH  = 3'b100;
  localparam logic [STATUS_W-1:0] CODE_MEMRD  = 3'b101;
  localparam logic [STATUS_W-1:0] CODE_MEMWR  = 3'b110;
  localparam logic [STATUS_W-1:0] CODE_IDLE   = 3'b111;

  // bit positions inside the command vector
  localparam int CMD_MEMRD = 0;
  localparam int CMD_MEMWR = 1;
  localparam int CMD_IORD  = 2;
  localparam int CMD_IOWR  = 3;
  localparam int CMD_INTA  = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LATCH = 2'd1,
    PH_CMD   = 2'd2
  } phaseE;

  typedef struct packed {
    logic captureCode;
    logic latchPhase;
    logic cmdPhase;
  } ctrlStrobesT;

  function automatic logic [CMD_W-1:0] decodeCmd(input logic [STATUS_W-1:0] code);
    logic [CMD_W-1:0] vec;
    vec = '0;
    case (code)
      CODE_INTA:              vec[CMD_INTA]  = 1'b1;
      CODE_IORD:              vec[CMD_IORD]  = 1'b1;
      CODE_IOWR:              vec[CMD_IOWR]  = 1'b1;
      CODE_FETCH, CODE_MEMRD: vec[CMD_MEMRD] = 1'b1;
      CODE_MEMWR:             vec[CMD_MEMWR] = 1'b1;
      default:                vec = '0;
    endcase
    return vec;
  endfunction

  function automatic logic isWriteCode(input logic [STATUS_W-1:0] code);
    return (code == CODE_IOWR) || (code == CODE_MEMWR);
  endfunction

endpackage

// File: rtl/busCmdControl.sv
module busCmdControl
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusIn,
  output ctrlStrobesT         strobes
);

  phaseE               phase;
  phaseE               phaseNext;
  logic [STATUS_W-1:0] prevStatus;
  logic                nowPassive;
  logic                startSeen;

  assign nowPassive = (statusIn == CODE_IDLE);
  assign startSeen  = (prevStatus == CODE_IDLE) && !nowPassive;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:  if (startSeen) phaseNext = PH_LATCH;
      PH_LATCH: phaseNext = nowPassive ? PH_IDLE : PH_CMD;
      PH_CMD:   if (nowPassive) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      prevStatus <= CODE_INTA;  // not passive: forces a passive sample first
    end else begin
      phase      <= phaseNext;
      prevStatus <= statusIn;
    end
  end

  assign strobes.captureCode = (phase == PH_IDLE) && startSeen;
  assign strobes.latchPhase  = (phase == PH_LATCH);
  assign strobes.cmdPhase    = (phase == PH_CMD);

  AST_LATCH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchPhase |=> !strobes.latchPhase); // R1

  AST_LATCH_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.latchPhase) |-> ($past(statusIn) != CODE_IDLE)); // R1

  AST_ABORT_ON_PASSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.latchPhase && nowPassive) |=> !strobes.cmdPhase && !strobes.latchPhase); // R8

  AST_NO_RESTART_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmdPhase |=> !strobes.latchPhase); // R7

endmodule

// File: rtl/busCmdDatapath.sv
module busCmdDatapath
  import busCmdPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [STATUS_W-1:0] statusIn,
  input  ctrlStrobesT         strobes,
  output logic                latchPulse,
  output logic                dirTx,
  output logic                dataEn,
  output logic [CMD_W-1:0]    cmdOut
);

  logic [STATUS_W-1:0] codeQ;
  logic [CMD_W-1:0]    cmdDecoded;
  logic                inCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= CODE_IDLE;
    end else if (strobes.captureCode) begin
      codeQ <= statusIn;
    end
  end

  assign cmdDecoded = decodeCmd(codeQ);
  assign inCycle    = strobes.latchPhase || strobes.cmdPhase;

  for (genvar i = 0; i < CMD_W; i++) begin : g_cmd
    assign cmdOut[i] = strobes.cmdPhase && cmdDecoded[i];
  end

  assign latchPulse = strobes.latchPhase;
  assign dirTx      = inCycle && isWriteCode(codeQ);
  assign dataEn     = strobes.cmdPhase && (codeQ != CODE_HALT);

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (inCycle && $past(inCycle)) |-> $stable(codeQ)); // R7

  AST_SINGLE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdOut)); // R4

  AST_DEN_APART_FROM_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !(latchPulse && dataEn)); // R5

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (inCycle && codeQ == CODE_HALT) |-> (cmdOut == '0) && !dataEn); // R3

endmodule

// File: rtl/busCmdController.sv
module busCmdController
  import busCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busStatus,
  output logic       addrLatchEn,
  output logic       dirTransmit,
  output logic       dataEnable,
  output logic       memRead,
  output logic       memWrite,
  output logic       ioRead,
  output logic       ioWrite,
  output logic       intAck
);

  ctrlStrobesT      strobes;
  logic [CMD_W-1:0] cmdVec;
  logic             anyCmd;

  busCmdControl uControl (
    .clk      (clk),
    .rstN     (rstN),
    .statusIn (busStatus),
    .strobes  (strobes)
  );

  busCmdDatapath uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .statusIn   (busStatus),
    .strobes    (strobes),
    .latchPulse (addrLatchEn),
    .dirTx      (dirTransmit),
    .dataEn     (dataEnable),
    .cmdOut     (cmdVec)
  );

  assign memRead  = cmdVec[CMD_MEMRD];
  assign memWrite = cmdVec[CMD_MEMWR];
  assign ioRead   = cmdVec[CMD_IORD];
  assign ioWrite  = cmdVec[CMD_IOWR];
  assign intAck   = cmdVec[CMD_INTA];
  assign anyCmd   = |cmdVec;

  AST_CMD_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyCmd) |-> $past(addrLatchEn)); // R4

  AST_CMD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (anyCmd && busStatus != CODE_IDLE) |=> anyCmd && $stable(cmdVec)); // R4

  AST_CMD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (anyCmd && busStatus == CODE_IDLE) |=> !anyCmd); // R4

  AST_DEN_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |-> dataEnable); // R5

  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (dirTransmit && !addrLatchEn) |-> $past(dirTransmit)); // R6

endmodule

// File: tb/busCmdController_test.sv
module busCmdController_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busStatus = 3'b101;
  logic       addrLatchEn, dirTransmit, dataEnable;
  logic       memRead, memWrite, ioRead, ioWrite, intAck;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit modelOn = 1'b0;

  int         mPhase = 0;
  logic [2:0] mCode  = 3'b111;
  logic [2:0] mPrev  = 3'b000;

  always #2.5 clk = ~clk;

  busCmdController uut (
    .clk(clk), .rstN(rstN), .busStatus(busStatus),
    .addrLatchEn(addrLatchEn), .dirTransmit(dirTransmit), .dataEnable(dataEnable),
    .memRead(memRead), .memWrite(memWrite), .ioRead(ioRead),
    .ioWrite(ioWrite), .intAck(intAck)
  );

  // packed view: {latch, memRd, memWr, ioRd, ioWr, intAck, den, dir}
  function automatic logic [7:0] actualVec();
    return {addrLatchEn, memRead, memWrite, ioRead, ioWrite, intAck, dataEnable, dirTransmit};
  endfunction

  function automatic logic isWr(input logic [2:0] c);
    return (c == 3'b010) || (c == 3'b110);
  endfunction

  function automatic logic [7:0] expectVec(input int ph, input logic [2:0] c);
    logic [7:0] v;
    v = 8'h00;
    if (ph == 1) begin
      v[7] = 1'b1;
      v[0] = isWr(c);
    end else if (ph == 2) begin
      case (c)
        3'b000:         v[2] = 1'b1;
        3'b001:         v[4] = 1'b1;
        3'b010:         v[3] = 1'b1;
        3'b100, 3'b101: v[6] = 1'b1;
        3'b110:         v[5] = 1'b1;
        default:        v[6:2] = 5'b0;
      endcase
      v[1] = (c != 3'b011);
      v[0] = isWr(c);
    end
    return v;
  endfunction

  function automatic string tagOf(input logic [7:0] diff);
    if (diff[7])        return "R1 latch pulse";
    else if (|diff[6:2]) return "R2 command strobe";
    else if (diff[1])   return "R5 data enable";
    else                return "R6 direction";
  endfunction

  task automatic look(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = actualVec();
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] s);
    @(negedge clk);
    busStatus = s;
  endtask

  // cycle-level model built from the requirements
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      mPrev  = 3'b000;
    end else begin
      case (mPhase)
        0: if (mPrev == 3'b111 && busStatus != 3'b111) begin
             mPhase = 1;
             mCode  = busStatus;
           end
        1: mPhase = (busStatus == 3'b111) ? 0 : 2;
        default: if (busStatus == 3'b111) mPhase = 0;
      endcase
      mPrev = busStatus;
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      logic [7:0] e;
      e = expectVec(mPhase, mCode);
      checks++;
      if (actualVec() !== e) begin
        fails++;
        $display("FAIL %s (model) actual=%b expected=%b at %0t",
                 tagOf(actualVec() ^ e), actualVec(), e, $time);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    look("R9 outputs low in reset", 8'h00);
    rstN = 1'b1;
    modelOn = 1'b1;
    // R9: non-passive right after reset must not start a cycle
    step(3'b101); look("R9 after release", 8'h00);
    step(3'b101); look("R9 no start without passive", 8'h00);
    step(3'b111); look("R9 still idle", 8'h00);
    step(3'b010); look("R9 idle while passive sampled", 8'h00);
    step(3'b010); look("R6 write latch dir high", 8'b1000_0001);
    step(3'b111); look("R5 io write window", 8'b0000_1011);
    step(3'b111); look("R4 released after passive", 8'h00);

    // R1/R2 memory read
    step(3'b101);
    step(3'b101); look("R1 latch pulse read", 8'b1000_0000);
    step(3'b101); look("R2 memory read", 8'b0100_0010);
    step(3'b111); look("R4 held until passive", 8'b0100_0010);
    step(3'b111); look("R4 low after passive", 8'h00);

    // R3 halt
    step(3'b011);
    step(3'b011); look("R3 halt latch", 8'b1000_0000);
    step(3'b011); look("R3 halt no command", 8'h00);
    step(3'b111); look("R3 halt quiet", 8'h00);
    step(3'b111);

    // R7 glitch during memory write
    step(3'b110);
    step(3'b110); look("R7 write latch", 8'b1000_0001);
    step(3'b001); look("R7 memory write", 8'b0010_0011);
    step(3'b000); look("R7 ignores code change", 8'b0010_0011);
    step(3'b111); look("R7 ignores second change", 8'b0010_0011);
    step(3'b111); look("R7 cycle ended", 8'h00);

    // R8 abort during latch clock
    step(3'b100);
    step(3'b111); look("R8 fetch latch", 8'b1000_0000);
    step(3'b111); look("R8 aborted no command", 8'h00);
    step(3'b111); look("R8 stays idle", 8'h00);

    // R10 back-to-back with single passive sample
    step(3'b001);
    step(3'b001); look("R10 first latch", 8'b1000_0000);
    step(3'b111); look("R10 io read", 8'b0001_0010);
    step(3'b000); look("R10 idle one clock", 8'h00);
    step(3'b000); look("R10 second latch", 8'b1000_0000);
    step(3'b111); look("R10 interrupt ack", 8'b0000_0110);
    step(3'b111); look("R10 ended", 8'h00);

    // random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 4;
      if (r < 2) step(3'b111);
      else step(3'($urandom % 8));
    end
    step(3'b111);
    step(3'b111);

    // reset in the middle of a cycle: R9
    step(3'b110);
    step(3'b110);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    look("R9 reset clears cycle", 8'h00);
    rstN = 1'b1;
    step(3'b110); look("R9 no start after mid-cycle reset", 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule